// File: doc/BRIEF.md
# Real-Time Clock and Calendar Core

This block keeps the time of day (second, minute, hour) and a calendar (century, year, month, day of week, date). It advances once for every pulse on a one-per-second tick input. Software reaches it through a plain register port with select, write strobe, word address and write data. Reads are combinational on the address. Every field in the time, calendar and alarm words is BCD. The hour is shown in 12-hour or 24-hour form. Internally all counters are binary and always in 24-hour form, so changing the display mode never alters the stored time.

Software freezes the time counters, the calendar counters or both through two separate request bits, then writes new values. A written value that is out of range is refused and recorded in a valid-entry register. Five sticky status flags report the following: update acknowledge, alarm, second event, a selectable time event and a selectable calendar event. Each flag can raise a single interrupt line through a mask that has separate set and clear registers.

The block carries no data stream, so the valid/ready convention does not apply. Every pin is a plain control or status pin, and the register port always accepts a write in the cycle it is strobed.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the time is 00:00:00 and the calendar reads century 20, year 00, month 01, date 01, day of week 6. The status, interrupt mask and valid-entry registers are 0, 24-hour mode is selected and `irq` is low.
- R2: Each `tick` pulse adds one second while time is running, carrying into the minute and hour, and from 23:59:59 into the next date. The time word (address 2) holds BCD second in bits 6:0, BCD minute in bits 14:8, BCD hour in bits 21:16 and the PM flag in bit 22.
- R3: Control register (address 0) bit 0 freezes the time counters and bit 1 freezes the calendar counters. A write to the time word or the calendar word takes effect only while its freeze bit is set. Otherwise the write is ignored and the valid-entry flags are unchanged. Status bit 0 (acknowledge) is set on every tick while either freeze bit is set.
- R4: Mode register (address 1) bit 0 set selects 12-hour form. In that form the hour reads 1 to 12 and bit 22 marks PM, with midnight shown as 12 AM and noon as 12 PM. In 24-hour form the hour reads 0 to 23 and bit 22 reads 0. Writes are interpreted in the current mode.
- R5: The calendar word (address 3) holds BCD century in bits 5:0, BCD year in bits 15:8, BCD month in bits 20:16, day of week (1 to 7) in bits 23:21 and BCD date in bits 29:24. Months have their calendar lengths, and February has 29 days when the year is divisible by 4. The day of week wraps from 7 to 1. Year 99 wraps to 00 and increments the century.
- R6: Status bit 2 is set on every tick that advances the time.
- R7: Status bit 3 is set when the time advances to a selected point. Control bits 9:8 select the point: 0 means each new minute, 1 means each new hour, 2 means 00:00:00, 3 means 12:00:00.
- R8: Status bit 4 is set when the date advances to a selected day. Control bits 17:16 select the day: 0 means Monday (day of week 1), 1 means the 1st of a month, 2 means January 1st, and 3 means never.
- R9: The time alarm word (address 4) uses the time-word layout, with enables for second (bit 7), minute (bit 15) and hour (bit 23). The calendar alarm word (address 5) has BCD month in bits 20:16 with enable bit 23, and BCD date in bits 29:24 with enable bit 31. Status bit 1 is set on a tick when the new time and date match every enabled field and at least one field is enabled.
- R10: A write with an out-of-range field is not stored, and it sets a flag in the valid-entry register (address 11). Bit 0 is for time, bit 1 for calendar, bit 2 for time alarm and bit 3 for calendar alarm. A later in-range write to the same register clears that flag. Century must be 19 or 20. An alarm field is range-checked only when its enable is set.
- R11: Writing 1s to the clear register (address 7) clears the matching status bits and leaves the others. A flag being set in the same cycle wins. Status reads at address 6.
- R12: Writing 1s to address 8 sets mask bits, and writing 1s to address 9 clears them. The mask reads at address 10. `irq` is high exactly when a status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- Stored time and date stay within their ranges.
- A frozen clock never moves unless it is written.
- The acknowledge, second-event and alarm flags rise only on a tick.
- The calendar event appears only with the time at 00:00:00.
- `irq` stays low with an empty mask.

Other behaviours can be shown only by the bench scenarios:
- Month lengths, the leap day, and the century and weekday wraps.
- The 12-hour presentation.
- Each event selector.
- Alarm matching on partial enables.
- Refusal of out-of-range entries.

These scenarios drive the block through exact rollover points and compare it with a behavioural model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int N_FLAGS = 5;
  localparam int N_NV    = 4;
  localparam int N_ALM   = 5;
  localparam int FLD_W   = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 4'd0, A_MODE = 4'd1, A_TIME = 4'd2, A_CAL = 4'd3,
    A_TALM = 4'd4, A_CALM = 4'd5, A_STAT = 4'd6, A_CLR = 4'd7,
    A_IEN = 4'd8, A_IDIS = 4'd9, A_IMASK = 4'd10, A_VALID = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic [6:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } tod_t;

  typedef struct packed {
    logic [6:0] cent;
    logic [6:0] yr;
    logic [3:0] mon;
    logic [2:0] dow;
    logic [4:0] date;
  } cal_t;

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(32'(v[7:4]) * 10 + 32'(v[3:0]));
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic bcd_ok(input logic [7:0] v, input int lo, input int hi);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9) &&
           (int'(bcd2bin(v)) >= lo) && (int'(bcd2bin(v)) <= hi);
  endfunction

  function automatic logic [4:0] mdays(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2: return (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default: return 5'd31;
    endcase
  endfunction

  // returns {ok, hour in 24-hour binary}
  function automatic logic [7:0] dec_hour(input logic [5:0] hf, input logic pm, input logic h12);
    logic [6:0] b;
    logic [6:0] h;
    logic ok;
    b = bcd2bin({2'b0, hf});
    if (h12) begin
      ok = bcd_ok({2'b0, hf}, 1, 12);
      h  = (b == 7'd12) ? 7'd0 : b;
      if (pm) h = h + 7'd12;
    end else begin
      ok = bcd_ok({2'b0, hf}, 0, 23);
      h  = b;
    end
    return {ok, h};
  endfunction

  // returns {pm, BCD hour field}
  function automatic logic [6:0] enc_hour(input logic [6:0] hr24, input logic h12);
    logic [6:0] h;
    logic [7:0] b;
    logic pm;
    pm = 1'b0;
    h  = hr24;
    if (h12) begin
      pm = (hr24 >= 7'd12);
      if (pm) h = hr24 - 7'd12;
      if (h == 7'd0) h = 7'd12;
    end
    b = bin2bcd(h);
    return {pm, b[5:0]};
  endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  tod_t t_i,
  input  cal_t c_i,
  output tod_t t_o,
  output cal_t c_o,
  output logic min_roll_o,
  output logic hr_roll_o,
  output logic day_roll_o,
  output logic noon_o,
  output logic mon_roll_o,
  output logic yr_roll_o
);
  logic sec_w, min_w, hr_w, date_w, mon_w, yr_w;

  always_comb begin
    sec_w  = (t_i.sc == 7'd59);
    min_w  = (t_i.mn == 7'd59);
    hr_w   = (t_i.hr == 7'd23);
    date_w = (c_i.date == mdays(c_i.mon, c_i.yr));
    mon_w  = (c_i.mon == 4'd12);
    yr_w   = (c_i.yr == 7'd99);

    t_o.sc = sec_w ? 7'd0 : t_i.sc + 7'd1;
    t_o.mn = !sec_w ? t_i.mn : (min_w ? 7'd0 : t_i.mn + 7'd1);
    t_o.hr = !(sec_w && min_w) ? t_i.hr : (hr_w ? 7'd0 : t_i.hr + 7'd1);

    min_roll_o = sec_w;
    hr_roll_o  = sec_w && min_w;
    day_roll_o = sec_w && min_w && hr_w;
    noon_o     = sec_w && min_w && (t_i.hr == 7'd11);
    mon_roll_o = date_w;
    yr_roll_o  = date_w && mon_w;

    c_o      = c_i;
    c_o.dow  = (c_i.dow == 3'd7) ? 3'd1 : c_i.dow + 3'd1;
    c_o.date = date_w ? 5'd1 : c_i.date + 5'd1;
    if (date_w) begin
      c_o.mon = mon_w ? 4'd1 : c_i.mon + 4'd1;
      if (mon_w) begin
        c_o.yr = yr_w ? 7'd0 : c_i.yr + 7'd1;
        if (yr_w) c_o.cent = c_i.cent + 7'd1;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int N_FIELDS = 5,
  parameter int FW       = 7
) (
  input  logic [N_FIELDS-1:0][FW-1:0] cur_i,
  input  logic [N_FIELDS-1:0][FW-1:0] ref_i,
  input  logic [N_FIELDS-1:0]         en_i,
  output logic                        hit_o
);
  logic [N_FIELDS-1:0] fld_ok;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    assign fld_ok[g] = !en_i[g] || (cur_i[g] == ref_i[g]);
  end

  assign hit_o = (|en_i) && (&fld_ok);
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_pkg::*;
#(
  parameter int RST_CENT = 20,
  parameter int RST_DOW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic upd_t, upd_c, h12;
  logic [1:0] tev_sel, cev_sel;
  tod_t tod_q, t_adv, t_dec, alm_t;
  cal_t cal_q, c_adv, c_dec, cal_nx;
  logic [3:0] alm_mon;
  logic [4:0] alm_date;
  logic [N_ALM-1:0]   alm_en;
  logic [N_FLAGS-1:0] stat, mask, set_v, clr_v;
  logic [N_NV-1:0]    nv;
  logic min_roll, hr_roll, day_roll, noon, mon_roll, yr_roll;
  logic run_t, cal_step, tev_hit, cev_hit, alm_hit;
  logic wr, wr_ctrl, wr_mode, wr_time, wr_cal, wr_talm, wr_calm;
  logic t_ok, c_ok, ta_ok, ca_ok;
  logic [7:0] hd;
  logic [6:0] eh_t, eh_a;
  logic [7:0] bs, bm, bh, bc, by, bmo, bd, bam, bad, bas, bamn;

  rtc_advance u_adv (
    .t_i(tod_q), .c_i(cal_q), .t_o(t_adv), .c_o(c_adv),
    .min_roll_o(min_roll), .hr_roll_o(hr_roll), .day_roll_o(day_roll),
    .noon_o(noon), .mon_roll_o(mon_roll), .yr_roll_o(yr_roll)
  );

  assign run_t    = tick && !upd_t;
  assign cal_step = run_t && day_roll && !upd_c;
  assign cal_nx   = cal_step ? c_adv : cal_q;

  rtc_alarm_cmp #(.N_FIELDS(N_ALM), .FW(FLD_W)) u_alm (
    .cur_i({{2'b0, cal_nx.date}, {3'b0, cal_nx.mon}, t_adv.hr, t_adv.mn, t_adv.sc}),
    .ref_i({{2'b0, alm_date}, {3'b0, alm_mon}, alm_t.hr, alm_t.mn, alm_t.sc}),
    .en_i(alm_en),
    .hit_o(alm_hit)
  );

  // write strobes
  assign wr      = bus_sel && bus_wr;
  assign wr_ctrl = wr && (bus_addr == A_CTRL);
  assign wr_mode = wr && (bus_addr == A_MODE);
  assign wr_time = wr && (bus_addr == A_TIME) && upd_t;
  assign wr_cal  = wr && (bus_addr == A_CAL) && upd_c;
  assign wr_talm = wr && (bus_addr == A_TALM);
  assign wr_calm = wr && (bus_addr == A_CALM);
  assign clr_v   = (wr && bus_addr == A_CLR) ? bus_wdata[N_FLAGS-1:0] : '0;

  // entry decode and range checks
  always_comb begin
    hd       = dec_hour(bus_wdata[21:16], bus_wdata[22], h12);
    t_dec.sc = bcd2bin({1'b0, bus_wdata[6:0]});
    t_dec.mn = bcd2bin({1'b0, bus_wdata[14:8]});
    t_dec.hr = hd[6:0];
    t_ok  = bcd_ok({1'b0, bus_wdata[6:0]}, 0, 59) && bcd_ok({1'b0, bus_wdata[14:8]}, 0, 59) && hd[7];
    ta_ok = (!bus_wdata[7]  || bcd_ok({1'b0, bus_wdata[6:0]}, 0, 59)) &&
            (!bus_wdata[15] || bcd_ok({1'b0, bus_wdata[14:8]}, 0, 59)) &&
            (!bus_wdata[23] || hd[7]);
    c_dec.cent = bcd2bin({2'b0, bus_wdata[5:0]});
    c_dec.yr   = bcd2bin(bus_wdata[15:8]);
    c_dec.mon  = 4'(bcd2bin({3'b0, bus_wdata[20:16]}));
    c_dec.dow  = bus_wdata[23:21];
    c_dec.date = 5'(bcd2bin({2'b0, bus_wdata[29:24]}));
    c_ok  = bcd_ok({2'b0, bus_wdata[5:0]}, 19, 20) && bcd_ok(bus_wdata[15:8], 0, 99) &&
            bcd_ok({3'b0, bus_wdata[20:16]}, 1, 12) && (bus_wdata[23:21] != 3'd0) &&
            bcd_ok({2'b0, bus_wdata[29:24]}, 1, int'(mdays(c_dec.mon, c_dec.yr)));
    ca_ok = (!bus_wdata[23] || bcd_ok({3'b0, bus_wdata[20:16]}, 1, 12)) &&
            (!bus_wdata[31] || bcd_ok({2'b0, bus_wdata[29:24]}, 1, 31));
  end

  // event selection
  always_comb begin
    case (tev_sel)
      2'd0:    tev_hit = min_roll;
      2'd1:    tev_hit = hr_roll;
      2'd2:    tev_hit = day_roll;
      default: tev_hit = noon;
    endcase
    case (cev_sel)
      2'd0:    cev_hit = (c_adv.dow == 3'd1);
      2'd1:    cev_hit = mon_roll;
      2'd2:    cev_hit = yr_roll;
      default: cev_hit = 1'b0;
    endcase
    set_v = {cal_step && cev_hit, run_t && tev_hit, run_t, run_t && alm_hit,
             tick && (upd_t || upd_c)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_t    <= 1'b0;
      upd_c    <= 1'b0;
      tev_sel  <= 2'd0;
      cev_sel  <= 2'd0;
      h12      <= 1'b0;
      tod_q    <= '0;
      cal_q    <= '{cent: 7'(RST_CENT), yr: 7'd0, mon: 4'd1, dow: 3'(RST_DOW), date: 5'd1};
      alm_t    <= '0;
      alm_mon  <= '0;
      alm_date <= '0;
      alm_en   <= '0;
      stat     <= '0;
      mask     <= '0;
      nv       <= '0;
    end else begin
      if (wr_ctrl) begin
        upd_t   <= bus_wdata[0];
        upd_c   <= bus_wdata[1];
        tev_sel <= bus_wdata[9:8];
        cev_sel <= bus_wdata[17:16];
      end
      if (wr_mode) h12 <= bus_wdata[0];
      if (run_t) tod_q <= t_adv;
      else if (wr_time && t_ok) tod_q <= t_dec;
      if (cal_step) cal_q <= c_adv;
      else if (wr_cal && c_ok) cal_q <= c_dec;
      if (wr_time) nv[0] <= !t_ok;
      if (wr_cal)  nv[1] <= !c_ok;
      if (wr_talm) begin
        nv[2] <= !ta_ok;
        if (ta_ok) begin
          alm_t       <= t_dec;
          alm_en[2:0] <= {bus_wdata[23], bus_wdata[15], bus_wdata[7]};
        end
      end
      if (wr_calm) begin
        nv[3] <= !ca_ok;
        if (ca_ok) begin
          alm_mon     <= 4'(bcd2bin({3'b0, bus_wdata[20:16]}));
          alm_date    <= 5'(bcd2bin({2'b0, bus_wdata[29:24]}));
          alm_en[4:3] <= {bus_wdata[31], bus_wdata[23]};
        end
      end
      stat <= (stat & ~clr_v) | set_v;
      if (wr && bus_addr == A_IEN)  mask <= mask | bus_wdata[N_FLAGS-1:0];
      if (wr && bus_addr == A_IDIS) mask <= mask & ~bus_wdata[N_FLAGS-1:0];
    end
  end

  assign irq = |(stat & mask);

  // read path: binary to BCD and 12/24-hour presentation
  always_comb begin
    eh_t = enc_hour(tod_q.hr, h12);
    eh_a = enc_hour(alm_t.hr, h12);
    bs   = bin2bcd(tod_q.sc);
    bm   = bin2bcd(tod_q.mn);
    bh   = bin2bcd(cal_q.cent);
    bc   = bin2bcd({2'b0, cal_q.date});
    by   = bin2bcd(cal_q.yr);
    bmo  = bin2bcd({3'b0, cal_q.mon});
    bas  = bin2bcd(alm_t.sc);
    bamn = bin2bcd(alm_t.mn);
    bam  = bin2bcd({3'b0, alm_mon});
    bad  = bin2bcd({2'b0, alm_date});
    bd   = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {14'b0, cev_sel, 6'b0, tev_sel, 6'b0, upd_c, upd_t};
      A_MODE:  bus_rdata = {31'b0, h12};
      A_TIME:  bus_rdata = {9'b0, eh_t[6], eh_t[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0]};
      A_CAL:   bus_rdata = {2'b0, bc[5:0], cal_q.dow, bmo[4:0], by, 2'b0, bh[5:0]};
      A_TALM:  bus_rdata = {8'b0, alm_en[2], eh_a[6], eh_a[5:0], alm_en[1], bamn[6:0],
                            alm_en[0], bas[6:0]};
      A_CALM:  bus_rdata = {alm_en[4], 1'b0, bad[5:0], alm_en[3], 2'b0, bam[4:0], 16'b0};
      A_STAT:  bus_rdata = {27'b0, stat};
      A_IMASK: bus_rdata = {27'b0, mask};
      A_VALID: bus_rdata = {28'b0, nv};
      default: bus_rdata = {24'b0, bd};
    endcase
  end
endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk
  import rtc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               irq,
  input logic               upd_t,
  input logic               wr_time,
  input tod_t               tod_q,
  input cal_t               cal_q,
  input logic [N_FLAGS-1:0] stat,
  input logic [N_FLAGS-1:0] mask
);
  assert_tod_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tod_q.sc <= 7'd59 && tod_q.mn <= 7'd59 && tod_q.hr <= 7'd23);

  assert_frozen_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_t && !wr_time) |=> $stable(tod_q));

  assert_ack_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(tick));

  assert_cal_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_q.date >= 5'd1 && cal_q.date <= 5'd31 && cal_q.mon >= 4'd1 &&
    cal_q.mon <= 4'd12 && cal_q.dow != 3'd0);

  assert_sec_event_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> $past(tick));

  assert_cal_event_midnight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> (tod_q == '0));

  assert_alarm_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(tick));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind rtc_cal_core rtc_cal_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .irq(irq), .upd_t(upd_t),
  .wr_time(wr_time), .tod_q(tod_q), .cal_q(cal_q), .stat(stat), .mask(mask)
);

// File: tb/test_rtc_cal_core.sv
module test_rtc_cal_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd;
  logic irq;
  int compared = 0, mismatched = 0;
  bit running = 0;

  // behavioural model
  int ms, mm, mh, mdate, mmon, myr, mcent, mdow;
  bit mupt, mupc, m12;
  int mtev, mcev;
  int a_s, a_m, a_h, a_mo, a_d;
  bit [4:0] a_en;
  bit [4:0] mstat, mmask;
  bit [3:0] mnv;

  rtc_cal_core i_rtc_cal_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bcd(int v);
    return (v / 10) * 16 + v % 10;
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] tw(int h, int m, int s, bit pm);
    return {9'b0, pm, 6'(bcd(h)), 1'b0, 7'(bcd(m)), 1'b0, 7'(bcd(s))};
  endfunction

  function automatic logic [31:0] cw(int c, int y, int mo, int dw, int d);
    return {2'b0, 6'(bcd(d)), 3'(dw), 5'(bcd(mo)), 8'(bcd(y)), 2'b0, 6'(bcd(c))};
  endfunction

  function automatic logic [31:0] exp_time();
    int h;
    bit pm;
    h = mh;
    pm = 0;
    if (m12) begin
      pm = (mh >= 12);
      h = mh % 12;
      if (h == 0) h = 12;
    end
    return tw(h, mm, ms, pm);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (running) chk("R12 irq per cycle", {31'b0, irq}, {31'b0, |(mstat & mmask)});

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic model_tick();
    bit roll;
    roll = 0;
    if (mupt || mupc) mstat[0] = 1;
    if (!mupt) begin
      ms++;
      if (ms == 60) begin ms = 0; mm++; end
      if (mm == 60) begin mm = 0; mh++; end
      if (mh == 24) begin mh = 0; roll = 1; end
      mstat[2] = 1;
      if ((mtev == 0 && ms == 0) || (mtev == 1 && ms == 0 && mm == 0) ||
          (mtev == 2 && ms == 0 && mm == 0 && mh == 0) ||
          (mtev == 3 && ms == 0 && mm == 0 && mh == 12)) mstat[3] = 1;
      if (roll && !mupc) begin
        mdow = (mdow == 7) ? 1 : mdow + 1;
        mdate++;
        if (mdate > dim(mmon, myr)) begin mdate = 1; mmon++; end
        if (mmon == 13) begin mmon = 1; myr++; end
        if (myr == 100) begin myr = 0; mcent++; end
        if ((mcev == 0 && mdow == 1) || (mcev == 1 && mdate == 1) ||
            (mcev == 2 && mdate == 1 && mmon == 1)) mstat[4] = 1;
      end
      if (a_en != 0 && (!a_en[0] || ms == a_s) && (!a_en[1] || mm == a_m) &&
          (!a_en[2] || mh == a_h) && (!a_en[3] || mmon == a_mo) && (!a_en[4] || mdate == a_d))
        mstat[1] = 1;
    end
  endtask

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(posedge clk); #1 tick = 0;
      model_tick();
    end
  endtask

  task automatic set_ctrl(bit ut, bit uc, int tev, int cev);
    bus_write(0, {14'b0, 2'(cev), 6'b0, 2'(tev), 6'b0, uc, ut});
    mupt = ut; mupc = uc; mtev = tev; mcev = cev;
  endtask

  task automatic set_mode(bit m);
    bus_write(1, {31'b0, m});
    m12 = m;
  endtask

  task automatic w_time(logic [31:0] w, bit ok, int h24, int m, int s);
    bus_write(2, w);
    if (mupt) begin
      mnv[0] = !ok;
      if (ok) begin mh = h24; mm = m; ms = s; end
    end
  endtask

  task automatic w_cal(logic [31:0] w, bit ok, int c, int y, int mo, int dw, int d);
    bus_write(3, w);
    if (mupc) begin
      mnv[1] = !ok;
      if (ok) begin mcent = c; myr = y; mmon = mo; mdow = dw; mdate = d; end
    end
  endtask

  task automatic clr_stat(bit [4:0] v);
    bus_write(7, {27'b0, v});
    mstat &= ~v;
  endtask

  task automatic chk_all(string tag);
    rd_reg(2, rd); chk({tag, " time"}, rd, exp_time());
    rd_reg(3, rd); chk({tag, " calendar"}, rd, cw(mcent, myr, mmon, mdow, mdate));
    rd_reg(6, rd); chk({tag, " status"}, rd, {27'b0, mstat});
    rd_reg(11, rd); chk({tag, " valid"}, rd, {28'b0, mnv});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    ms = 0; mm = 0; mh = 0; mdate = 1; mmon = 1; myr = 0; mcent = 20; mdow = 6;
    mupt = 0; mupc = 0; m12 = 0; mtev = 0; mcev = 0;
    a_s = 0; a_m = 0; a_h = 0; a_mo = 0; a_d = 0; a_en = 0;
    mstat = 0; mmask = 0; mnv = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1;
    // R1 reset state
    chk_all("R1 reset");
    rd_reg(10, rd); chk("R1 mask", rd, 0);
    rd_reg(1, rd); chk("R1 mode", rd, 0);

    // R2 / R6 counting, second event
    do_ticks(3);
    chk_all("R2 R6 count");

    // R3 writes ignored while running, then freeze and ack
    w_time(tw(10, 20, 30, 0), 1, 10, 20, 30);
    rd_reg(2, rd); chk("R3 write ignored", rd, exp_time());
    rd_reg(11, rd); chk("R3 valid unchanged", rd, 0);
    set_ctrl(1, 1, 2, 1);
    clr_stat(5'h1f);
    do_ticks(2);
    chk_all("R3 frozen ack");
    w_time(tw(23, 59, 50, 0), 1, 23, 59, 50);
    w_cal(cw(20, 24, 2, 3, 28), 1, 20, 24, 2, 3, 28);
    chk_all("R3 written");

    // R5 / R7 leap day, midnight event, no month event
    set_ctrl(0, 0, 2, 1);
    clr_stat(5'h1f);
    do_ticks(10);
    chk_all("R5 R7 leap day");

    // R8 month event Feb 29 -> Mar 1
    set_ctrl(1, 0, 2, 1);
    w_time(tw(23, 59, 59, 0), 1, 23, 59, 59);
    set_ctrl(0, 0, 2, 1);
    clr_stat(5'h1f);
    do_ticks(1);
    chk_all("R5 R8 month change");

    // R5 / R8 year and century wrap
    set_ctrl(1, 1, 1, 2);
    w_time(tw(23, 59, 59, 0), 1, 23, 59, 59);
    w_cal(cw(19, 99, 12, 5, 31), 1, 19, 99, 12, 5, 31);
    set_ctrl(0, 0, 1, 2);
    clr_stat(5'h1f);
    do_ticks(1);
    chk_all("R5 R8 century wrap");

    // R5 / R8 non-leap February, weekday wrap to Monday
    set_ctrl(1, 1, 0, 0);
    w_time(tw(23, 59, 59, 0), 1, 23, 59, 59);
    w_cal(cw(20, 23, 2, 7, 28), 1, 20, 23, 2, 7, 28);
    set_ctrl(0, 0, 0, 0);
    clr_stat(5'h1f);
    do_ticks(1);
    chk_all("R5 R8 monday");

    // R4 12-hour presentation and noon event
    set_mode(1);
    chk_all("R4 midnight 12h");
    set_ctrl(1, 0, 3, 3);
    w_time(tw(11, 59, 58, 0), 1, 11, 59, 58);
    chk_all("R4 12h write");
    set_ctrl(0, 0, 3, 3);
    clr_stat(5'h1f);
    do_ticks(1);
    chk_all("R4 R7 before noon");
    do_ticks(1);
    chk_all("R4 R7 noon pm");
    set_mode(0);
    chk_all("R4 back to 24h");

    // R10 out-of-range entries
    set_ctrl(1, 1, 0, 3);
    w_time(tw(24, 0, 0, 0), 0, 0, 0, 0);
    w_cal(cw(20, 23, 2, 3, 29), 0, 0, 0, 0, 0, 0);
    bus_write(4, {8'b0, 1'b0, 1'b0, 6'h00, 1'b0, 7'h00, 1'b1, 7'h60}); mnv[2] = 1;
    bus_write(5, {1'b0, 1'b0, 6'h01, 1'b1, 2'b0, 5'h13, 16'b0}); mnv[3] = 1;
    chk_all("R10 rejected");
    w_time(tw(0, 0, 58, 0), 1, 0, 0, 58);
    chk_all("R10 cleared");

    // R9 alarm on second 05 of minute 01; hour field disabled but out of range
    bus_write(4, {8'b0, 1'b0, 1'b0, 6'h3f, 1'b1, 7'h01, 1'b1, 7'h05});
    mnv[2] = 0; a_s = 5; a_m = 1; a_en = 5'b00011;
    bus_write(5, 32'h0); mnv[3] = 0;
    set_ctrl(0, 0, 1, 3);
    clr_stat(5'h1f);
    do_ticks(6);
    chk_all("R9 before match");
    // R12 enable alarm interrupt before it fires
    bus_write(8, 32'h2); mmask |= 5'h2;
    rd_reg(10, rd); chk("R12 mask set", rd, 32'h2);
    do_ticks(1);
    chk_all("R9 match");
    rd_reg(6, rd); chk("R12 irq high", {31'b0, irq}, 32'h1);

    // R11 clear only alarm, others remain
    clr_stat(5'h02);
    chk_all("R11 partial clear");
    bus_write(9, 32'h2); mmask &= ~5'h2;
    rd_reg(10, rd); chk("R12 mask cleared", rd, 0);

    // R9 calendar alarm field match with date enabled
    bus_write(4, 32'h0); a_en[2:0] = 0;
    bus_write(5, {1'b1, 1'b0, 6'(bcd(mdate)), 1'b0, 2'b0, 5'h00, 16'b0});
    a_en[4] = 1; a_d = mdate;
    clr_stat(5'h1f);
    do_ticks(1);
    chk_all("R9 date alarm");

    running = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule